// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing for a raster display. Software writes five setup words (horizontal total/active, horizontal sync, vertical total/active, vertical sync, line pitch) and one control word through a plain register write port. The block then steps a pixel position across each line and down each frame, and from that position derives horizontal sync, vertical sync, a display-enable flag and the byte address of the first pixel of the current line.

Totals and active widths on the horizontal axis are programmed in 8-pixel character units. Sync positions are programmed in pixels on the horizontal axis and in lines on the vertical axis. Each sync has its own polarity bit. Every setup word goes first into a shadow copy. The shadow copies move into the working set only on the clock edge that begins a new frame, or at any time while the block is disabled, so a mode change never tears a frame. The timing outputs form a free-running stream with no valid/ready handshake and no back-pressure: the display side consumes one pixel position per clock. The write port is a plain strobe with no stall.

Register map, selected by `wr_addr`: 0 control, 1 horizontal total/active, 2 horizontal sync, 3 vertical total/active, 4 vertical sync, 5 pitch. The control word is not shadowed and takes effect on the clock after the write.

Top module: `crt_timing_gen`

## Requirements
- R1: After reset, `pix_x`, `pix_y` and `line_addr` are 0, `de` is low, and both syncs are low, because the reset polarity is active-high.
- R2: With the block enabled, `pix_x` counts up by one each clock from 0 to 8·(H+1)−1, where H is bits [9:0] of word 1. It then returns to 0, and `pix_y` advances by one. After line V, where V is bits [15:0] of word 3, `pix_y` returns to 0.
- R3: `de` is high exactly when `pix_x` < 8·(D+1) and `pix_y` ≤ E. D is bits [24:16] of word 1 and E is bits [31:16] of word 3.
- R4: The horizontal sync is active for pixels S ≤ `pix_x` < S+W. S is bits [12:0] of word 2 and W is bits [21:16] of word 2. When bit 23 of word 2 is 1 the output is active-low; otherwise it is active-high.
- R5: The vertical sync is active for lines L+1 ≤ `pix_y` < L+1+N. L is bits [11:0] of word 4 and N is bits [20:16] of word 4. Bit 23 of word 4 selects active-low in the same way. The output changes only at the start of a line.
- R6: Bit 0 of the control word enables the block. While it is 0, the position counters are held at 0 from the second clock on, `de` is low, and each sync sits at its inactive level.
- R7: A write to words 1–5 during a running frame does not change the outputs of that frame. The new value applies from the first pixel of the next frame.
- R8: `line_addr` is 0 on line 0 of every frame. It rises by P·8·2^B at each new line and is constant within a line. P is bits [15:0] of word 5 and B is bits [2:1] of the control word, giving log2 of bytes per pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (0 control, 1–5 setup words) |
| wr_data | input | 32 | Register write value |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| de | output | 1 | High while inside the active area |
| pix_x | output | 13 | Current pixel column |
| pix_y | output | V_W (12) | Current line |
| line_addr | output | ADDR_W (24) | Byte address of the current line's first pixel |

## Verification
A counter that misses its terminal count shows up within one line as a `pix_x` that passes the programmed total, or as a `pix_y` that does not advance, and the position comparison catches it on that pixel. A working set that loads at the wrong moment, or a sync window decoded off by one, moves `de` or a sync edge by a pixel or a line in the first frame it affects. A wrong step or a missed clear in the line-address accumulator is visible on the first pixel of line 1, or on the first pixel of the next frame.

// File: rtl/crt_pkg.sv
`timescale 1ns/1ps
package crt_pkg;

  // pixel column width: 10-bit character total times 8 pixels
  localparam int HX_W   = 13;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL  = 3'd0,
    RA_HTIME = 3'd1,
    RA_HSYNC = 3'd2,
    RA_VTIME = 3'd3,
    RA_VSYNC = 3'd4,
    RA_PITCH = 3'd5
  } reg_addr_e;

  // decoded working / shadow timing set
  typedef struct packed {
    logic [9:0]  htot_c;    // total characters minus one
    logic [8:0]  hdisp_c;   // active characters minus one
    logic [12:0] hs_start;  // sync start pixel
    logic [5:0]  hs_wid;    // sync width in pixels
    logic        hs_pol;    // 1 = active low
    logic [15:0] vtot_m1;   // total lines minus one
    logic [15:0] vdisp_m1;  // active lines minus one
    logic [11:0] vs_m1;     // sync start line minus one
    logic [4:0]  vs_wid;    // sync width in lines
    logic        vs_pol;    // 1 = active low
    logic [15:0] pitch;     // line pitch in 8-pixel units
  } crt_timing_t;

endpackage

// File: rtl/crt_regfile.sv
`timescale 1ns/1ps
module crt_regfile
  import crt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              load,
  output logic              ctrl_en,
  output logic [1:0]        bpp_log2,
  output crt_timing_t       act
);

  crt_timing_t shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      bpp_log2 <= 2'd0;
      shadow   <= '0;
      act      <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          RA_CTRL: begin
            ctrl_en  <= wr_data[0];
            bpp_log2 <= wr_data[2:1];
          end
          RA_HTIME: begin
            shadow.htot_c  <= wr_data[9:0];
            shadow.hdisp_c <= wr_data[24:16];
          end
          RA_HSYNC: begin
            shadow.hs_start <= wr_data[12:0];
            shadow.hs_wid   <= wr_data[21:16];
            shadow.hs_pol   <= wr_data[23];
          end
          RA_VTIME: begin
            shadow.vtot_m1  <= wr_data[15:0];
            shadow.vdisp_m1 <= wr_data[31:16];
          end
          RA_VSYNC: begin
            shadow.vs_m1  <= wr_data[11:0];
            shadow.vs_wid <= wr_data[20:16];
            shadow.vs_pol <= wr_data[23];
          end
          RA_PITCH: shadow.pitch <= wr_data[15:0];
          default: ;
        endcase
      end
      // working set follows the shadow only at a frame boundary
      if (load) act <= shadow;
    end
  end

endmodule

// File: rtl/crt_pos_counter.sv
`timescale 1ns/1ps
module crt_pos_counter
  import crt_pkg::*;
#(
  parameter int V_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [9:0]      htot_c,
  input  logic [V_W-1:0]  vlast,
  output logic [HX_W-1:0] x,
  output logic [V_W-1:0]  y,
  output logic            line_end,
  output logic            frame_end
);

  logic [HX_W-1:0] xlast;

  assign xlast     = {htot_c, 3'b111};
  assign line_end  = (x == xlast);
  assign frame_end = line_end && (y == vlast);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      x <= '0;
      y <= '0;
    end else if (line_end) begin
      x <= '0;
      y <= frame_end ? '0 : y + 1'b1;
    end else begin
      x <= x + 1'b1;
    end
  end

endmodule

// File: rtl/crt_window.sv
`timescale 1ns/1ps
module crt_window #(
  parameter int PW = 13,
  parameter int SW = 13,
  parameter int WW = 6
) (
  input  logic          en,
  input  logic [PW-1:0] pos,
  input  logic [SW-1:0] start,
  input  logic [WW-1:0] width,
  input  logic          pol,
  output logic          sync
);

  localparam int CW = ((PW > SW) ? PW : SW) + 2;

  logic [CW-1:0] pos_e, st_e, end_e;
  logic          active;

  assign pos_e  = CW'(pos);
  assign st_e   = CW'(start);
  assign end_e  = st_e + CW'(width);
  assign active = en && (pos_e >= st_e) && (pos_e < end_e);
  assign sync   = active ^ pol;

endmodule

// File: rtl/crt_line_addr.sv
`timescale 1ns/1ps
module crt_line_addr #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              line_end,
  input  logic              frame_end,
  input  logic [15:0]       pitch,
  input  logic [1:0]        bpp_log2,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] step;

  // pitch in characters -> pixels -> bytes
  assign step = ADDR_W'({pitch, 3'b000}) << bpp_log2;

  always_ff @(posedge clk) begin
    if (!rst_n || !en)   addr <= '0;
    else if (frame_end)  addr <= '0;
    else if (line_end)   addr <= addr + step;
  end

endmodule

// File: rtl/crt_timing_gen.sv
`timescale 1ns/1ps
module crt_timing_gen
  import crt_pkg::*;
#(
  parameter int V_W    = 12,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [12:0]       pix_x,
  output logic [V_W-1:0]    pix_y,
  output logic [ADDR_W-1:0] line_addr
);

  crt_timing_t act;
  logic        ctrl_en;
  logic [1:0]  bpp_log2;
  logic        line_end, frame_end, load;
  logic [12:0] vs_start;
  logic        h_in, v_in;
  logic        unused_hi;

  assign load = !ctrl_en || frame_end;

  crt_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .load     (load),
    .ctrl_en  (ctrl_en),
    .bpp_log2 (bpp_log2),
    .act      (act)
  );

  crt_pos_counter #(.V_W(V_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl_en),
    .htot_c    (act.htot_c),
    .vlast     (act.vtot_m1[V_W-1:0]),
    .x         (pix_x),
    .y         (pix_y),
    .line_end  (line_end),
    .frame_end (frame_end)
  );

  assign vs_start = {1'b0, act.vs_m1} + 13'd1;

  crt_window #(.PW(13), .SW(13), .WW(6)) u_hwin (
    .en    (ctrl_en),
    .pos   (pix_x),
    .start (act.hs_start),
    .width (act.hs_wid),
    .pol   (act.hs_pol),
    .sync  (hsync)
  );

  crt_window #(.PW(V_W), .SW(13), .WW(5)) u_vwin (
    .en    (ctrl_en),
    .pos   (pix_y),
    .start (vs_start),
    .width (act.vs_wid),
    .pol   (act.vs_pol),
    .sync  (vsync)
  );

  // active area: column character index <= last active character
  assign h_in = (pix_x[12:3] <= {1'b0, act.hdisp_c});
  assign v_in = (17'(pix_y) <= 17'(act.vdisp_m1));
  assign de   = ctrl_en && h_in && v_in;

  crt_line_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl_en),
    .line_end  (line_end),
    .frame_end (frame_end),
    .pitch     (act.pitch),
    .bpp_log2  (bpp_log2),
    .addr      (line_addr)
  );

  assign unused_hi = ^{act.vtot_m1};

endmodule

// File: rtl/crt_timing_chk.sv
`timescale 1ns/1ps
module crt_timing_chk #(
  parameter int V_W    = 12,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              line_end,
  input logic              de,
  input logic              vsync,
  input logic [12:0]       pix_x,
  input logic [V_W-1:0]    pix_y,
  input logic [ADDR_W-1:0] line_addr
);

  // R6
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (pix_x == '0 && pix_y == '0 && !de));

  // R2
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !line_end) |=> (pix_x == $past(pix_x) + 13'd1));

  // R2
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !line_end) |=> $stable(pix_y));

  // R8
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != '0) |-> $stable(line_addr));

  // R8
  addr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x == '0 && pix_y == '0) |-> (line_addr == '0));

  // R5
  vsync_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pix_x != '0) |-> $stable(vsync));

endmodule

bind crt_timing_gen crt_timing_chk #(.V_W(V_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (ctrl_en),
  .line_end  (line_end),
  .de        (de),
  .vsync     (vsync),
  .pix_x     (pix_x),
  .pix_y     (pix_y),
  .line_addr (line_addr)
);

// File: tb/tb_crt_timing_gen.sv
`timescale 1ns/1ps
module tb_crt_timing_gen;

  localparam int V_W    = 12;
  localparam int ADDR_W = 24;

  // columns: htot px, hdisp px, hs start, hs width, hpol,
  //          vtot, vdisp, vs line, vs width, vpol, pitch, bpp_log2
  localparam int MODES [0:2][0:11] = '{
    '{32, 16, 20, 4, 0, 10, 6, 7, 2, 0, 4, 0},
    '{48, 40, 42, 3, 1,  8, 5, 5, 1, 1, 5, 2},
    '{16, 16,  0, 5, 0,  4, 4, 3, 1, 0, 2, 1}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [2:0]        wr_addr;
  logic [31:0]       wr_data;
  logic              hsync, vsync, de;
  logic [12:0]       pix_x;
  logic [V_W-1:0]    pix_y;
  logic [ADDR_W-1:0] line_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  crt_timing_gen #(.V_W(V_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .line_addr(line_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup_raw(input logic [31:0] w1, w2, w3, w4, w5, ctl);
    wr(0, 32'd0);
    wr(1, w1); wr(2, w2); wr(3, w3); wr(4, w4); wr(5, w5);
    wr(0, ctl);
  endtask

  task automatic setup_mode(input int m);
    setup_raw(32'((MODES[m][0]/8 - 1) | ((MODES[m][1]/8 - 1) << 16)),
              32'(MODES[m][2] | (MODES[m][3] << 16) | (MODES[m][4] << 23)),
              32'((MODES[m][5] - 1) | ((MODES[m][6] - 1) << 16)),
              32'((MODES[m][7] - 1) | (MODES[m][8] << 16) | (MODES[m][9] << 23)),
              32'(MODES[m][10] | (MODES[m][10] << 16)),
              32'(1 | (MODES[m][11] << 1)));
  endtask

  // walk two frames of mode m pixel by pixel against the requirement model
  task automatic run_mode(input int m);
    int  bad_pos = 0, bad_hs = 0, bad_vs = 0, bad_de = 0, bad_ad = 0;
    longint a_pos = 0, e_pos = 0, a_hs = 0, e_hs = 0, a_vs = 0, e_vs = 0;
    longint a_de = 0, e_de = 0, a_ad = 0, e_ad = 0;
    setup_mode(m);
    for (int f = 0; f < 2; f++) begin
      for (int y = 0; y < MODES[m][5]; y++) begin
        for (int x = 0; x < MODES[m][0]; x++) begin
          bit     ehs, evs, ede;
          longint ead;
          ehs = ((x >= MODES[m][2]) && (x < MODES[m][2] + MODES[m][3])) ^ (MODES[m][4] != 0);
          evs = ((y >= MODES[m][7]) && (y < MODES[m][7] + MODES[m][8])) ^ (MODES[m][9] != 0);
          ede = (x < MODES[m][1]) && (y < MODES[m][6]);
          ead = (longint'(y) * MODES[m][10] * 8 * (1 << MODES[m][11])) & ((64'd1 << ADDR_W) - 1);
          if (pix_x != 13'(x) || pix_y != V_W'(y)) begin
            if (bad_pos == 0) begin a_pos = pix_x + 10000 * pix_y; e_pos = x + 10000 * y; end
            bad_pos++;
          end
          if (hsync != ehs) begin if (bad_hs == 0) begin a_hs = hsync; e_hs = ehs; end bad_hs++; end
          if (vsync != evs) begin if (bad_vs == 0) begin a_vs = vsync; e_vs = evs; end bad_vs++; end
          if (de != ede)    begin if (bad_de == 0) begin a_de = de; e_de = ede; end bad_de++; end
          if (longint'(line_addr) != ead) begin
            if (bad_ad == 0) begin a_ad = line_addr; e_ad = ead; end
            bad_ad++;
          end
          @(negedge clk);
        end
      end
    end
    check(bad_pos == 0, "R2", $sformatf("mode%0d position x+10000*y", m), a_pos, e_pos);
    check(bad_hs == 0,  "R4", $sformatf("mode%0d hsync", m), a_hs, e_hs);
    check(bad_vs == 0,  "R5", $sformatf("mode%0d vsync", m), a_vs, e_vs);
    check(bad_de == 0,  "R3", $sformatf("mode%0d de", m), a_de, e_de);
    check(bad_ad == 0,  "R8", $sformatf("mode%0d line_addr", m), a_ad, e_ad);
  endtask

  task automatic wait_pos(input int x, input int y);
    while (!(pix_x == 13'(x) && pix_y == V_W'(y))) @(negedge clk);
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(pix_x == 0 && pix_y == 0, "R1", "position after reset", pix_x + 10000 * pix_y, 0);
    check(!de && !hsync && !vsync, "R1", "de/hsync/vsync after reset", {de, hsync, vsync}, 0);
    check(line_addr == 0, "R1", "line_addr after reset", line_addr, 0);

    // table walk
    for (int m = 0; m < 3; m++) run_mode(m);

    // R6 disable while running, active-low polarities in mode 1
    setup_mode(1);
    repeat (37) @(negedge clk);
    wr(0, 32'd0);
    check(!de && hsync && vsync, "R6", "outputs inactive on disable", {de, hsync, vsync}, 3'b011);
    @(negedge clk);
    check(pix_x == 0 && pix_y == 0, "R6", "counters cleared", pix_x + 10000 * pix_y, 0);
    repeat (5) @(negedge clk);
    check(pix_x == 0 && pix_y == 0 && !de && line_addr == 0, "R6", "held while disabled",
          pix_x + line_addr, 0);

    // R7 shadow: widen active area mid-frame in mode 0
    setup_mode(0);
    wait_pos(0, 3);
    wr(1, 32'(3 | (2 << 16)));
    wait_pos(20, 3);
    check(de == 1'b0, "R7", "de at x=20 same frame (old width 16)", de, 0);
    wait_pos(20, 0);
    check(de == 1'b1, "R7", "de at x=20 next frame (new width 24)", de, 1);
    wait_pos(24, 0);
    check(de == 1'b0, "R7", "de at x=24 next frame", de, 0);

    // reference mode, horizontal line 0 in full
    setup_raw(32'(99 | (79 << 16)), 32'(674 | (12 << 16) | (1 << 23)),
              32'(524 | (479 << 16)), 32'(490 | (2 << 16) | (1 << 23)),
              32'(80 | (80 << 16)), 32'd1);
    begin
      int bad_h = 0, bad_d = 0, bad_v = 0;
      for (int x = 0; x < 800; x++) begin
        if (hsync != !((x >= 674) && (x < 686))) bad_h++;
        if (de != (x < 640)) bad_d++;
        if (vsync != 1'b1) bad_v++;
        @(negedge clk);
      end
      check(bad_h == 0, "R4", "reference hsync 674..685 active low", bad_h, 0);
      check(bad_d == 0, "R3", "reference de for x<640", bad_d, 0);
      check(bad_v == 0, "R5", "reference vsync idle high on line 0", bad_v, 0);
    end
    check(pix_x == 0 && pix_y == 1, "R2", "reference wrap after 800 pixels",
          pix_x + 10000 * pix_y, 10000);
    check(line_addr == 640, "R8", "reference line 1 address", line_addr, 640);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule